// File: doc/BRIEF.md
# Module Power State Sequencer

This block holds the power and clock state of a group of peripheral modules that share one always-on domain. Software writes a requested state into each module's control register. Those requests are only staged. A single command write commits every staged change at once, and a busy flag stays high until every module that was asked to change has acknowledged. Each module's acknowledge is modelled as a fixed latency of `ACK_LAT` clock cycles.

From each module's current state, the block drives a clock-enable output and an active-low reset output. Software reaches the block through a 32-bit register port with a combinational read path. The port offers these registers:

- one control register per module, at 0xA00 + 4·i;
- one read-only status register per module, at 0x800 + 4·i;
- a command register at 0x120;
- a busy register at 0x128.

Top module: `pmsq_top`

## Requirements
- R1: After reset, every control register and every current state is 0, the busy bit at 0x128 reads 0, every `mod_clk_en` bit is 0 and every `mod_rst_n` bit is 0.
- R2: A write to 0xA00 + 4·i stores all 32 bits, and the same address reads them back unchanged. The requested state is bits [4:0]. Writing the control register alone changes neither the module's current state nor its outputs.
- R3: A write to 0x120 with bit 0 = 1 while idle sets bit 0 of 0x128 in the next cycle. A write to 0x120 with bit 0 = 0 has no effect.
- R4: When a command is accepted, every module whose bits [4:0] differ from its current state adopts the requested value exactly `ACK_LAT` cycles after the accepting edge. The busy bit clears one cycle after the last such module has adopted its state.
- R5: The register at 0x800 + 4·i reads the current state of module i in bits [4:0], with bits [31:5] zero.
- R6: Each state drives the outputs as follows. State 3 gives clock enabled and reset released. State 2 gives clock off and reset released. Every other code (0, 1 and 4–31) gives clock off and reset asserted (`mod_rst_n` = 0).
- R7: A command written while busy is ignored. It neither restarts the acknowledge countdown nor applies any value.
- R8: Control writes made during a transition are staged and take effect only at the next accepted command. The target of a transition is the value captured at its command.
- R9: A command accepted when no module has a pending change holds busy high for exactly one cycle.
- R10: Reads of 0x120 and of any unmapped offset return 0. This includes control and status offsets at module index `N_MOD` or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte offset for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| mod_clk_en | output | N_MOD | Per-module clock enable |
| mod_rst_n | output | N_MOD | Per-module active-low reset |

## Verification
The assertions check these properties on every cycle:

- an accepted command always raises busy;
- a module is never pending while the block is idle;
- busy drops as soon as nothing is pending;
- current states stay frozen while idle;
- no module ever has its clock on while held in reset;
- status words never carry bits above the state field.

Only the bench scenarios can show the rest. These are the exact acknowledge timing, that a command during busy leaves the target and countdown untouched, that staged writes wait for the next command, and that the full 32-bit control contents survive. The bench shows these by comparing against its own reference model on every clock and by directed reads.

// File: rtl/pmsq_pkg.sv
package pmsq_pkg;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned FIELD_W = 5;

  localparam logic [ADDR_W-1:0] CTRL_BASE = 12'hA00;
  localparam logic [ADDR_W-1:0] STAT_BASE = 12'h800;
  localparam logic [ADDR_W-1:0] CMD_ADDR  = 12'h120;
  localparam logic [ADDR_W-1:0] BUSY_ADDR = 12'h128;

  localparam logic [FIELD_W-1:0] ST_ON     = 5'd3;
  localparam logic [FIELD_W-1:0] ST_CLKOFF = 5'd2;

  // Byte offset of the word belonging to module idx in a window.
  function automatic logic [ADDR_W-1:0] reg_addr(logic [ADDR_W-1:0] base, int idx);
    return base + ADDR_W'(4 * idx);
  endfunction

  function automatic logic st_clk_en(logic [FIELD_W-1:0] s);
    return s == ST_ON;
  endfunction

  function automatic logic st_rst_rel(logic [FIELD_W-1:0] s);
    return (s == ST_ON) || (s == ST_CLKOFF);
  endfunction
endpackage

// File: rtl/pmsq_slot.sv
module pmsq_slot
  import pmsq_pkg::*;
#(
  parameter int unsigned ACK_LAT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_we,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               go_accept,
  output logic [DATA_W-1:0]  ctrl_q,
  output logic [FIELD_W-1:0] cur_q,
  output logic               pend_q,
  output logic               clk_en,
  output logic               rst_rel
);
  localparam int unsigned CNT_W = $clog2(ACK_LAT + 1);

  logic [CNT_W-1:0]   cnt_q;
  logic [FIELD_W-1:0] tgt_q;
  logic               changed;

  assign changed = ctrl_q[FIELD_W-1:0] != cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cur_q  <= '0;
      tgt_q  <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata;
      if (go_accept && changed) begin
        pend_q <= 1'b1;
        cnt_q  <= CNT_W'(ACK_LAT - 1);
        tgt_q  <= ctrl_q[FIELD_W-1:0];
      end else if (pend_q) begin
        if (cnt_q == '0) begin
          pend_q <= 1'b0;
          cur_q  <= tgt_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign clk_en  = st_clk_en(cur_q);
  assign rst_rel = st_rst_rel(cur_q);
endmodule

// File: rtl/pmsq_seq.sv
module pmsq_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic go_req,
  input  logic pend_any,
  output logic go_accept,
  output logic busy_q
);
  assign go_accept = go_req && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   busy_q <= 1'b0;
    else if (go_accept)           busy_q <= 1'b1;
    else if (busy_q && !pend_any) busy_q <= 1'b0;
  end
endmodule

// File: rtl/pmsq_top.sv
module pmsq_top
  import pmsq_pkg::*;
#(
  parameter int unsigned N_MOD   = 4,
  parameter int unsigned ACK_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [11:0]       addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [N_MOD-1:0]  mod_clk_en,
  output logic [N_MOD-1:0]  mod_rst_n
);
  localparam int unsigned CUR_W = N_MOD * FIELD_W;

  logic [DATA_W-1:0]  ctrl_v [N_MOD];
  logic [FIELD_W-1:0] cur_v  [N_MOD];
  logic [N_MOD-1:0]   pend_v;
  logic [CUR_W-1:0]   cur_flat;
  logic               go_req, go_acc, busy_q;

  assign go_req = wr_en && (addr == CMD_ADDR) && wdata[0];

  pmsq_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go_req(go_req), .pend_any(|pend_v),
    .go_accept(go_acc), .busy_q(busy_q)
  );

  for (genvar g = 0; g < N_MOD; g++) begin : g_slot
    logic we_g;
    assign we_g = wr_en && (addr == reg_addr(CTRL_BASE, g));
    pmsq_slot #(.ACK_LAT(ACK_LAT)) u_slot (
      .clk(clk), .rst_n(rst_n), .ctrl_we(we_g), .wdata(wdata),
      .go_accept(go_acc), .ctrl_q(ctrl_v[g]), .cur_q(cur_v[g]),
      .pend_q(pend_v[g]), .clk_en(mod_clk_en[g]), .rst_rel(mod_rst_n[g])
    );
    assign cur_flat[g*FIELD_W +: FIELD_W] = cur_v[g];
  end

  always_comb begin
    rdata = '0;
    if (addr == BUSY_ADDR) rdata = {{(DATA_W-1){1'b0}}, busy_q};
    for (int i = 0; i < N_MOD; i++) begin
      if (addr == reg_addr(CTRL_BASE, i)) rdata = ctrl_v[i];
      if (addr == reg_addr(STAT_BASE, i)) rdata = {{(DATA_W-FIELD_W){1'b0}}, cur_v[i]};
    end
  end
endmodule

// File: rtl/pmsq_chk.sv
module pmsq_chk #(
  parameter int unsigned N_MOD = 4,
  parameter int unsigned CUR_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go_accept,
  input logic             busy,
  input logic [N_MOD-1:0] pend,
  input logic [CUR_W-1:0] cur_flat,
  input logic [N_MOD-1:0] mod_clk_en,
  input logic [N_MOD-1:0] mod_rst_n,
  input logic [3:0]       page,
  input logic [26:0]      rdata_hi
);
  p_go_sets_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go_accept |=> busy);

  p_pend_needs_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) |-> busy);

  p_idle_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(cur_flat));

  p_no_clk_in_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_clk_en & ~mod_rst_n) == '0);

  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(|pend) && !go_accept) |=> !busy);

  p_status_hi_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (page == 4'h8) |-> (rdata_hi == '0));
endmodule

bind pmsq_top pmsq_chk #(.N_MOD(N_MOD), .CUR_W(N_MOD * 5)) u_chk (
  .clk(clk), .rst_n(rst_n), .go_accept(go_acc), .busy(busy_q),
  .pend(pend_v), .cur_flat(cur_flat), .mod_clk_en(mod_clk_en),
  .mod_rst_n(mod_rst_n), .page(addr[11:8]), .rdata_hi(rdata[31:5])
);

// File: tb/sim_pmsq_top.sv
`timescale 1ns/1ps
module sim_pmsq_top;
  localparam int N   = 4;
  localparam int LAT = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] mod_clk_en, mod_rst_n;

  int total = 0, bad = 0;
  bit done = 0, running = 0;

  always #10 clk = ~clk;

  pmsq_top #(.N_MOD(N), .ACK_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .mod_clk_en(mod_clk_en), .mod_rst_n(mod_rst_n)
  );

  // Behavioural reference model
  logic [31:0] ctrl_m [N];
  logic [4:0]  cur_m  [N];
  logic [4:0]  tgt_m  [N];
  int          cnt_m  [N];
  bit          busy_m, was_busy, anyp;

  always @(posedge clk) begin
    if (!rst_n) begin
      busy_m = 0;
      for (int i = 0; i < N; i++) begin
        ctrl_m[i] = 0; cur_m[i] = 0; tgt_m[i] = 0; cnt_m[i] = 0;
      end
    end else begin
      was_busy = busy_m;
      anyp = 0;
      for (int i = 0; i < N; i++) if (cnt_m[i] > 0) anyp = 1;
      for (int i = 0; i < N; i++)
        if (cnt_m[i] > 0) begin
          cnt_m[i]--;
          if (cnt_m[i] == 0) cur_m[i] = tgt_m[i];
        end
      if (was_busy && !anyp) busy_m = 0;
      if (wr_en && addr == 12'h120 && wdata[0] && !was_busy) begin
        busy_m = 1;
        for (int i = 0; i < N; i++)
          if (ctrl_m[i][4:0] != cur_m[i]) begin
            cnt_m[i] = LAT; tgt_m[i] = ctrl_m[i][4:0];
          end
      end
      if (wr_en)
        for (int i = 0; i < N; i++)
          if (addr == 12'hA00 + 12'(4 * i)) ctrl_m[i] = wdata;
    end
  end

  function automatic logic [31:0] model_read(logic [11:0] a);
    logic [31:0] v = 0;
    if (a == 12'h128) v = {31'b0, busy_m};
    for (int i = 0; i < N; i++) begin
      if (a == 12'hA00 + 12'(4 * i)) v = ctrl_m[i];
      if (a == 12'h800 + 12'(4 * i)) v = {27'b0, cur_m[i]};
    end
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    #5;
    if (running) begin
      logic [N-1:0] ce, rr;
      for (int i = 0; i < N; i++) begin
        ce[i] = (cur_m[i] == 5'd3);
        rr[i] = (cur_m[i] == 5'd3) || (cur_m[i] == 5'd2);
      end
      check("R6 clk_en vs model", 32'(mod_clk_en), 32'(ce));
      check("R6 rst_n vs model", 32'(mod_rst_n), 32'(rr));
      check("R4 rdata vs model", rdata, model_read(addr));
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; wdata = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    running = 1;
    @(negedge clk);

    // R1: reset state
    rd(12'hA00, v); check("R1 ctrl0", v, 0);
    rd(12'h800, v); check("R1 status0", v, 0);
    rd(12'h128, v); check("R1 busy", v, 0);
    check("R1 clk_en", 32'(mod_clk_en), 0);
    check("R1 rst_n", 32'(mod_rst_n), 0);

    // R2: full-width store, no effect before command
    wr(12'hA08, 32'hDEAD_BE02);
    rd(12'hA08, v); check("R2 readback", v, 32'hDEAD_BE02);
    rd(12'h808, v); check("R2 status unchanged", v, 0);
    check("R2 rst_n2 still asserted", 32'(mod_rst_n[2]), 0);

    // R3: command with bit0=0 ignored
    wr(12'h120, 32'hFFFF_FFFE);
    rd(12'h128, v); check("R3 no busy on bit0=0", v, 0);

    // R3/R4: accepted command, timing
    wr(12'h120, 1);
    rd(12'h128, v); check("R3 busy set", v, 1);
    rd(12'h808, v); check("R4 not yet", v, 0);
    repeat (3) @(negedge clk);
    rd(12'h808, v); check("R4 still waiting", v, 0);
    @(negedge clk);
    rd(12'h808, v); check("R4 adopted after ACK_LAT", v, 2);
    rd(12'h128, v); check("R4 busy held", v, 1);
    check("R6 state2 clk off", 32'(mod_clk_en[2]), 0);
    check("R6 state2 reset released", 32'(mod_rst_n[2]), 1);
    @(negedge clk);
    rd(12'h128, v); check("R4 busy cleared", v, 0);
    rd(12'h808, v); check("R5 status word", v, 32'h2);

    // R9: nothing pending
    wr(12'h120, 1);
    rd(12'h128, v); check("R9 busy one cycle", v, 1);
    @(negedge clk);
    rd(12'h128, v); check("R9 busy dropped", v, 0);

    // R7/R8: command during busy ignored, write staged
    wr(12'hA04, 3);
    wr(12'h120, 1);
    wr(12'hA04, 2);
    wr(12'h120, 1);
    @(negedge clk);
    @(negedge clk);
    rd(12'h804, v); check("R7 original target applied", v, 3);
    check("R6 state3 clk on", 32'(mod_clk_en[1]), 1);
    @(negedge clk);
    rd(12'h128, v); check("R7 countdown not restarted", v, 0);
    rd(12'hA04, v); check("R8 staged value held", v, 2);
    rd(12'h804, v); check("R8 staged not applied", v, 3);
    wr(12'h120, 1);
    repeat (4) @(negedge clk);
    rd(12'h804, v); check("R8 applied at next command", v, 2);
    repeat (2) @(negedge clk);

    // R6: other codes
    wr(12'hA00, 1);
    wr(12'hA0C, 5);
    wr(12'hA04, 3);
    wr(12'h120, 1);
    repeat (6) @(negedge clk);
    check("R6 clk_en mix", 32'(mod_clk_en), 32'b0010);
    check("R6 rst_n mix", 32'(mod_rst_n), 32'b0110);
    rd(12'h80C, v); check("R5 status code 5", v, 5);

    // R10: unmapped reads
    rd(12'h120, v); check("R10 cmd reads 0", v, 0);
    rd(12'h300, v); check("R10 unmapped", v, 0);
    rd(12'hA10, v); check("R10 ctrl beyond N", v, 0);
    rd(12'h810, v); check("R10 status beyond N", v, 0);

    repeat (2) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule